// File: doc/BRIEF.md
# Target Programming Status Monitor

This block runs on the programmer side of a socket and watches a 4-bit status bus that the target device drives during a fuse-programming run or a secure-boot check. The bus has pull-downs, so while the target has not booted it reads `0000`. The pins come from another clock domain and may glitch. The block therefore passes them through a two-stage synchroniser and then a stability filter. A new status value counts only after `FILT_LEN` identical samples in a row. Each time the accepted value changes, the block judges that change against the expected progress of the current operation.

An operation begins with a one-cycle `start` while the block is idle. `verify_mode` is sampled on that cycle and selects between a program run and a verify run. In a program run the target must report, in this order: firmware booted, fuse phase one started, phase one ended, phase one passed, fuse phase two started, phase two ended, and finally overall pass. In a verify run the single accepted change that leaves `0000` decides the outcome. A cycle counter limits every run to `TIMEOUT_CYCLES` clock cycles. When the run ends, `busy` drops, `done` pulses, and `pass` and `reason` hold the outcome until the next start.

The state machine has these states. `ST_IDLE` waits for start. `ST_VERIFY` waits for the verdict. For program runs, `ST_BOOT` expects `0001`, `ST_SETUP` expects `0110`, `ST_P1_RUN` expects `0111`, `ST_P1_END` expects `1000`/`1001`, `ST_P2_WAIT` expects `0010`, `ST_P2_RUN` expects `0011` and `ST_P2_END` expects `0100`/`0101`. The transitions are:

- start: `ST_IDLE` to `ST_BOOT` or `ST_VERIFY`.
- advance: an expected code moves to the next program state.
- finish: any verdict, error or timeout returns to `ST_IDLE`.

Top module: `pstat_monitor`

## Requirements
- R1: After reset `busy`, `done` and `pass` are 0 and `reason` is 0 (none).
- R2: A status change on the pins is acted on only after it has been seen on `FILT_LEN` consecutive synchronised samples. A shorter excursion away from the accepted value and back has no effect on the outcome.
- R3: `start` while idle raises `busy` on the next cycle, clears `pass` and `reason`, and samples `verify_mode` (1 = verify, 0 = program). `start` while busy is ignored, and so is a later change of `verify_mode`.
- R4: In a program run, the accepted sequence 0001, 0110, 0111, 1000, 0010, 0011, 0100 ends the run with `pass`=1 and `reason`=0.
- R5: In a program run, 1001 in place of 1000 ends with reason 3 (phase one failed). 0101 in place of 0100 ends with reason 4 (phase two failed).
- R6: In a program run, an accepted 1100 at any point ends with reason 5 (invalid command). An accepted 1101 ends with reason 6 (settings checksum error).
- R7: In a program run, any other accepted change that is not the next expected code ends with reason 7 (sequence error).
- R8: In a verify run, the first accepted change decides the result. 1010 ends with `pass`=1. 1011 ends with reason 8 (explicit verify failure). Any other value ends with reason 9 (unexpected verify status).
- R9: A run with no verdict ends `TIMEOUT_CYCLES` cycles after the start cycle. The reason is 2 (settings never arrived) if a program run was waiting right after 0001, and 1 (timeout) otherwise.
- R10: A run ends with `done` high for exactly one cycle, in the same cycle that `busy` falls. `pass` and `reason` stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| verify_mode | input | 1 | Run type sampled at start: 1 verify, 0 program |
| status_pins | input | 4 | Raw status bus from the target, asynchronous |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe at the end of a run |
| pass | output | 1 | Outcome of the last run |
| reason | output | 4 | Failure reason code of the last run, 0 on pass |

## Verification
The bench builds the block with `FILT_LEN` = 3 and `TIMEOUT_CYCLES` = 200. With these values a two-sample glitch falls just short of acceptance. Each timeout path, including the "settings never arrived" case, also ends within a few hundred cycles. A behavioural model keeps a history of raw pin samples and an integer progress index. It predicts every output on every clock, so the filter latency, the cycle in which the timeout fires, and the one-cycle `done` strobe are all compared exactly.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

    localparam int STAT_W = 4;

    typedef enum logic [3:0] {
        RSN_NONE        = 4'd0,
        RSN_TIMEOUT     = 4'd1,
        RSN_NO_SETTINGS = 4'd2,
        RSN_PH1_FAIL    = 4'd3,
        RSN_PH2_FAIL    = 4'd4,
        RSN_BAD_CMD     = 4'd5,
        RSN_CHECKSUM    = 4'd6,
        RSN_SEQUENCE    = 4'd7,
        RSN_VFY_FAIL    = 4'd8,
        RSN_VFY_BAD     = 4'd9
    } reason_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BOOT,
        ST_SETUP,
        ST_P1_RUN,
        ST_P1_END,
        ST_P2_WAIT,
        ST_P2_RUN,
        ST_P2_END,
        ST_VERIFY
    } state_e;

    localparam logic [STAT_W-1:0] CODE_IDLE     = 4'b0000;
    localparam logic [STAT_W-1:0] CODE_BOOT     = 4'b0001;
    localparam logic [STAT_W-1:0] CODE_P2_START = 4'b0010;
    localparam logic [STAT_W-1:0] CODE_P2_END   = 4'b0011;
    localparam logic [STAT_W-1:0] CODE_ALL_PASS = 4'b0100;
    localparam logic [STAT_W-1:0] CODE_ALL_FAIL = 4'b0101;
    localparam logic [STAT_W-1:0] CODE_P1_START = 4'b0110;
    localparam logic [STAT_W-1:0] CODE_P1_END   = 4'b0111;
    localparam logic [STAT_W-1:0] CODE_P1_PASS  = 4'b1000;
    localparam logic [STAT_W-1:0] CODE_P1_FAIL  = 4'b1001;
    localparam logic [STAT_W-1:0] CODE_VFY_PASS = 4'b1010;
    localparam logic [STAT_W-1:0] CODE_VFY_FAIL = 4'b1011;
    localparam logic [STAT_W-1:0] CODE_BAD_CMD  = 4'b1100;
    localparam logic [STAT_W-1:0] CODE_CHECKSUM = 4'b1101;

endpackage

// File: rtl/pstat_sync_filter.sv
module pstat_sync_filter #(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc,
    output logic         chg
);

    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0][W-1:0] sync_q;
    logic [W-1:0]                  cand_q;
    logic [CW-1:0]                 cnt_q;
    logic [W-1:0]                  samp;

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Candidate value and run length; accepted once the run hits FILT_LEN.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '0;
            cnt_q  <= '0;
            acc    <= '0;
            chg    <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (samp != cand_q) begin
                cand_q <= samp;
                cnt_q  <= CW'(1);
            end else if (cnt_q != CW'(FILT_LEN)) begin
                cnt_q <= cnt_q + CW'(1);
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    acc <= cand_q;
                    chg <= (cand_q != acc);
                end
            end
        end
    end

endmodule

// File: rtl/pstat_timer.sv
module pstat_timer #(
    parameter int unsigned LIMIT = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (clear) begin
            tmr_q <= '0;
        end else if (run && !expired) begin
            tmr_q <= tmr_q + TW'(1);
        end
    end

    assign expired = (tmr_q == TW'(LIMIT - 1));

endmodule

// File: rtl/pstat_monitor.sv
module pstat_monitor
    import pstat_pkg::*;
#(
    parameter int          FILT_LEN       = 4,
    parameter int unsigned TIMEOUT_CYCLES = 500_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       verify_mode,
    input  logic [3:0] status_pins,
    output logic       busy,
    output logic       done,
    output logic       pass,
    output logic [3:0] reason
);

    logic [STAT_W-1:0] code;
    logic              code_chg;
    logic              expired;
    logic              start_ok;
    state_e            state_q, state_d;
    logic              fin;
    logic              fin_pass;
    reason_e           fin_rsn;

    pstat_sync_filter #(
        .W          (STAT_W),
        .SYNC_STAGES(2),
        .FILT_LEN   (FILT_LEN)
    ) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (status_pins),
        .acc  (code),
        .chg  (code_chg)
    );

    pstat_timer #(
        .LIMIT(TIMEOUT_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_ok),
        .run    (busy),
        .expired(expired)
    );

    assign start_ok = start && (state_q == ST_IDLE);

    function automatic logic [STAT_W-1:0] code_for(state_e s);
        case (s)
            ST_BOOT:    return CODE_BOOT;
            ST_SETUP:   return CODE_P1_START;
            ST_P1_RUN:  return CODE_P1_END;
            ST_P1_END:  return CODE_P1_PASS;
            ST_P2_WAIT: return CODE_P2_START;
            ST_P2_RUN:  return CODE_P2_END;
            ST_P2_END:  return CODE_ALL_PASS;
            default:    return CODE_IDLE;
        endcase
    endfunction

    function automatic state_e next_of(state_e s);
        case (s)
            ST_BOOT:    return ST_SETUP;
            ST_SETUP:   return ST_P1_RUN;
            ST_P1_RUN:  return ST_P1_END;
            ST_P1_END:  return ST_P2_WAIT;
            ST_P2_WAIT: return ST_P2_RUN;
            ST_P2_RUN:  return ST_P2_END;
            default:    return ST_IDLE;
        endcase
    endfunction

    // Next state and run outcome
    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_pass = 1'b0;
        fin_rsn  = RSN_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = verify_mode ? ST_VERIFY : ST_BOOT;
                end
            end
            ST_VERIFY: begin
                if (code_chg) begin
                    fin = 1'b1;
                    if (code == CODE_VFY_PASS) begin
                        fin_pass = 1'b1;
                    end else if (code == CODE_VFY_FAIL) begin
                        fin_rsn = RSN_VFY_FAIL;
                    end else begin
                        fin_rsn = RSN_VFY_BAD;
                    end
                end else if (expired) begin
                    fin     = 1'b1;
                    fin_rsn = RSN_TIMEOUT;
                end
            end
            default: begin
                if (code_chg) begin
                    if (code == CODE_BAD_CMD) begin
                        fin     = 1'b1;
                        fin_rsn = RSN_BAD_CMD;
                    end else if (code == CODE_CHECKSUM) begin
                        fin     = 1'b1;
                        fin_rsn = RSN_CHECKSUM;
                    end else if (code == code_for(state_q)) begin
                        if (state_q == ST_P2_END) begin
                            fin      = 1'b1;
                            fin_pass = 1'b1;
                        end else begin
                            state_d = next_of(state_q);
                        end
                    end else if (state_q == ST_P1_END && code == CODE_P1_FAIL) begin
                        fin     = 1'b1;
                        fin_rsn = RSN_PH1_FAIL;
                    end else if (state_q == ST_P2_END && code == CODE_ALL_FAIL) begin
                        fin     = 1'b1;
                        fin_rsn = RSN_PH2_FAIL;
                    end else begin
                        fin     = 1'b1;
                        fin_rsn = RSN_SEQUENCE;
                    end
                end else if (expired) begin
                    fin     = 1'b1;
                    fin_rsn = (state_q == ST_SETUP) ? RSN_NO_SETTINGS : RSN_TIMEOUT;
                end
            end
        endcase
        if (fin) begin
            state_d = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            pass   <= 1'b0;
            reason <= RSN_NONE;
        end else begin
            done <= 1'b0;
            if (start_ok) begin
                busy   <= 1'b1;
                pass   <= 1'b0;
                reason <= RSN_NONE;
            end else if (fin) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                pass   <= fin_pass;
                reason <= fin_rsn;
            end
        end
    end

endmodule

// File: rtl/pstat_monitor_chk.sv
module pstat_monitor_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 500_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       pass,
    input logic [3:0] reason
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + CW'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(reason) && $stable(pass)));

    p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_pass_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (reason == 4'd0));

    p_timeout_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CW'(TIMEOUT_CYCLES)));

endmodule

bind pstat_monitor pstat_monitor_chk #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .pass  (pass),
    .reason(reason)
);

// File: tb/pstat_monitor_tb.sv
`timescale 1ns/1ps
module pstat_monitor_tb;

    localparam int          FL = 3;
    localparam int unsigned TO = 200;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       vmode;
    logic [3:0] pins;
    logic       busy, done, pass;
    logic [3:0] reason;

    always #2 clk = ~clk;

    pstat_monitor #(
        .FILT_LEN      (FL),
        .TIMEOUT_CYCLES(TO)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .verify_mode(vmode),
        .status_pins(pins),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .reason     (reason)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int hist[$];
    bit m_busy, m_done, m_pass, m_chg, m_vfy;
    int m_reason, m_acc, m_stage, m_t;
    int done_seen;

    function automatic int exp_code(int s);
        case (s)
            0: return 1;
            1: return 6;
            2: return 7;
            3: return 8;
            4: return 2;
            5: return 3;
            6: return 4;
            default: return -1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < FL + 2; i++) hist.push_back(0);
        m_busy = 0; m_done = 0; m_pass = 0; m_reason = 0;
        m_acc = 0; m_chg = 0; m_stage = 0; m_t = 0; m_vfy = 0;
    endtask

    task automatic model_step();
        bit fin;
        bit same;
        int nacc;
        fin = 0;
        m_done = 0;
        if (!m_busy) begin
            if (start) begin
                m_busy = 1; m_vfy = vmode; m_stage = 0; m_t = 0;
                m_pass = 0; m_reason = 0;
            end
        end else begin
            if (m_chg) begin
                fin = 1;
                if (m_vfy) begin
                    if (m_acc == 10) m_pass = 1;
                    else if (m_acc == 11) m_reason = 8;
                    else m_reason = 9;
                end else if (m_acc == 12) m_reason = 5;
                else if (m_acc == 13) m_reason = 6;
                else if (m_acc == exp_code(m_stage)) begin
                    if (m_stage == 6) m_pass = 1;
                    else begin m_stage++; fin = 0; end
                end else if (m_stage == 3 && m_acc == 9) m_reason = 3;
                else if (m_stage == 6 && m_acc == 5) m_reason = 4;
                else m_reason = 7;
            end else if (m_t == TO - 1) begin
                fin = 1;
                m_reason = (!m_vfy && m_stage == 1) ? 2 : 1;
            end
            if (fin) begin m_busy = 0; m_done = 1; end
            else m_t++;
        end
        // pin history: accepted value is the sample two edges back once the
        // last FL samples ending there agree
        hist.push_back(int'(pins));
        if (hist.size() > FL + 2) void'(hist.pop_front());
        same = 1;
        for (int i = 1; i < FL; i++) if (hist[i] != hist[0]) same = 0;
        nacc = same ? hist[FL-1] : m_acc;
        m_chg = (nacc != m_acc);
        m_acc = nacc;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(busy == m_busy, cur_req, "busy", busy, m_busy);
        check(done == m_done, cur_req, "done", done, m_done);
        check(pass == m_pass, cur_req, "pass", pass, m_pass);
        check(int'(reason) == m_reason, cur_req, "reason", reason, m_reason);
        if (done) done_seen++;
    endtask

    task automatic hold(input int code, input int n);
        pins = code[3:0];
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic go(input bit mode);
        vmode = mode;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic finish_run(input string req, input bit exp_pass, input int exp_rsn);
        int guard = 0;
        while (busy && guard < TO + 20) begin tick(); guard++; end
        check(done_seen == 1, req, "done pulses", done_seen, 1);
        check(pass == exp_pass, req, "final pass", pass, exp_pass);
        check(int'(reason) == exp_rsn, req, "final reason", reason, exp_rsn);
        hold(0, FL + 6);
        check(int'(reason) == exp_rsn, "R10", "reason held", reason, exp_rsn);
        done_seen = 0;
    endtask

    task automatic prog_seq(input int upto);
        int seq[7] = '{1, 6, 7, 8, 2, 3, 4};
        for (int i = 0; i < upto; i++) hold(seq[i], 6);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; vmode = 1'b0; pins = 4'd0;
        done_seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        // R1 reset state
        check(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
        check(pass == 0 && reason == 0, "R1", "pass/reason", {pass, reason}, 0);
        hold(0, 4);

        // R4 full program pass
        cur_req = "R4";
        go(0);
        check(busy == 1, "R3", "busy after start", busy, 1);
        prog_seq(7);
        finish_run("R4", 1, 0);

        // R2 short glitch ignored, then R5 phase one failure
        cur_req = "R2";
        go(0);
        hold(1, 6); hold(6, 2); hold(1, 6);
        check(busy == 1, "R2", "glitch ignored", busy, 1);
        hold(6, 6); hold(7, 6); hold(9, 6);
        finish_run("R5", 0, 3);

        // R5 phase two failure
        cur_req = "R5";
        go(0);
        prog_seq(6); hold(5, 6);
        finish_run("R5", 0, 4);

        // R6 invalid command and checksum error
        cur_req = "R6";
        go(0);
        prog_seq(2); hold(12, 6);
        finish_run("R6", 0, 5);
        go(0);
        prog_seq(4); hold(13, 6);
        finish_run("R6", 0, 6);

        // R7 out of order
        cur_req = "R7";
        go(0);
        hold(1, 6); hold(2, 6);
        finish_run("R7", 0, 7);

        // R8 verify outcomes
        cur_req = "R8";
        go(1); hold(10, 8);
        finish_run("R8", 1, 0);
        go(1); hold(11, 8);
        finish_run("R8", 0, 8);
        go(1); hold(6, 8);
        finish_run("R8", 0, 9);

        // R9 timeouts
        cur_req = "R9";
        go(0); hold(1, TO + 4);
        finish_run("R9", 0, 2);
        go(0); hold(0, TO + 4);
        finish_run("R9", 0, 1);
        go(1); hold(0, TO + 4);
        finish_run("R9", 0, 1);
        go(0); prog_seq(3); hold(7, TO);
        finish_run("R9", 0, 1);

        // R3 start and mode change while busy are ignored
        cur_req = "R3";
        go(0);
        hold(1, 6);
        go(1);
        check(busy == 1, "R3", "busy kept", busy, 1);
        vmode = 1'b1;
        hold(6, 6); hold(7, 6); hold(8, 6); hold(2, 6); hold(3, 6); hold(4, 6);
        finish_run("R3", 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule